// File: doc/BRIEF.md
# External Reset Pin Manager

This block looks after a bidirectional, active-low system reset pin. It runs on the slow clock. The pin input passes through a synchronizer, and each new low level on the pin is reported upward. Depending on the mode register, the report is either a single-cycle user-reset pulse to the reset sequencer or a single-cycle interrupt. A sticky status flag records that the pin went low. The flag stays set until software reads the status register. The live, synchronized pin level can be read at any time.

When the reset sequencer raises its external-reset request, the block drives the pin low for 2^(E+1) slow-clock cycles, where E is a small exponent field in the mode register. The same drive happens straight after power-on reset, using the reset value of E. Lows that the block causes itself are masked, so they never come back as user resets. If something outside still holds the pin low once the block lets go, that level is reported once.

The drive sequencer has three states:
- ST_POR_DRIVE is the reset state.
- ST_EXT_DRIVE is entered from any state when a request is seen, and each entry reloads the counter.
- ST_IDLE is entered from either drive state when the counter reaches zero with no request present. The pin is released there.

Top module: `rst_pin_mgr`

## Requirements
- R1: After power-on reset is released, the pin is driven for exactly 2 cycles (pin_oe=1, pin_out=0) and then released. The mode register reads back as exponent 0, interrupt-select 0 and user-reset-enable 1.
- R2: When ext_rst_req is sampled high in ST_IDLE, pin_oe is high for exactly 2^(E+1) cycles, starting the cycle after that edge. This holds for every exponent value E.
- R3: A request sampled high while the pin is being driven restarts the count, so pin_oe stays high 2^(E+1) cycles after the latest request.
- R4: With user-reset-enable=1 and interrupt-select=0, a low on an idle, high pin gives one usr_rst pulse of a single cycle. The pulse is high in the cycle after the third clock edge following the pin change. Holding the pin low gives no further pulses.
- R5: With user-reset-enable=0, a pin low gives no usr_rst pulse.
- R6: With interrupt-select=1, a pin low gives one single-cycle irq pulse and no usr_rst pulse.
- R7: Status bit 1 (reg_sel=1) shows the synchronized pin level.
- R8: Status bit 0 is set by every reported pin low, whatever the enables are. It stays set until a status read strobe (reg_rd with reg_sel=1) clears it.
- R9: Lows caused by the block's own drive, including the two synchronizer cycles after release, give no usr_rst, no irq and do not set the sticky flag.
- R10: If the pin is still held low externally when the mask window ends, including after power-up, exactly one low is reported.
- R11: Writes use reg_sel=0 with reg_wr. Field positions are exponent in bits [EXP_W-1:0], interrupt-select in bit EXP_W and user-reset-enable in bit EXP_W+1. reg_rdata reads the mode register combinationally when reg_sel=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Slow clock |
| rst_n | input | 1 | Power-on reset, active low |
| ext_rst_req | input | 1 | External-reset request from the reset sequencer |
| pin_in | input | 1 | Pad input of the reset pin |
| pin_out | output | 1 | Pad output value (always low) |
| pin_oe | output | 1 | Pad output enable |
| usr_rst | output | 1 | User-reset pulse to the sequencer |
| irq | output | 1 | Interrupt pulse |
| reg_sel | input | 1 | 0 selects the mode register, 1 the status register |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (clears sticky when reg_sel=1) |
| reg_wdata | input | EXP_W+2 | Write data |
| reg_rdata | output | EXP_W+2 | Read data |

## Verification
The bench builds the block with EXP_W=3. This keeps the longest pulse at 256 cycles, so every exponent from 0 to 7 can be swept and its pulse length counted against 2^(E+1). At this size a restart in mid-pulse can be measured directly. The bench covers every pair of user-reset-enable and interrupt-select values with a pad model in which driving wins over the external level. It also repeats power-on reset with the pin held low, to reach the masked-then-reported path.

// File: rtl/rst_pin_pkg.sv
package rst_pin_pkg;

    typedef enum logic [1:0] {
        ST_POR_DRIVE = 2'd0,
        ST_IDLE      = 2'd1,
        ST_EXT_DRIVE = 2'd2
    } drv_state_t;

    localparam int STS_STICKY = 0;
    localparam int STS_LEVEL  = 1;

endpackage

// File: rtl/rst_pin_sync.sv
module rst_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic drive_i,
    output logic level_o,
    output logic event_o
);
    logic [STAGES-1:0] sync_q;
    logic [STAGES-1:0] hist_q;
    logic              armed_q;
    logic              mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q  <= '1;
            hist_q  <= '1;
            armed_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin_i};
            hist_q <= {hist_q[STAGES-2:0], drive_i};
            if (!mask) begin
                armed_q <= sync_q[STAGES-1];
            end
        end
    end

    always_comb begin
        level_o = sync_q[STAGES-1];
        mask    = drive_i | (|hist_q);
        event_o = armed_q && !mask && !sync_q[STAGES-1];
    end

    // R4: after a report, no second report follows without the pin going high first
    p_one_report_r4: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |=> !event_o);

endmodule

// File: rtl/rst_pin_pulse.sv
module rst_pin_pulse
    import rst_pin_pkg::*;
#(
    parameter int EXP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [EXP_W-1:0] exp_i,
    output logic             drive_o
);
    localparam int CNT_W = 1 << EXP_W;

    drv_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] len_m1;
    logic [EXP_W:0]   sh_amt;

    always_comb begin
        sh_amt = {1'b0, exp_i} + (EXP_W+1)'(1);
        len_m1 = CNT_W'(((CNT_W+1)'(1) << sh_amt) - (CNT_W+1)'(1));
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_i) begin
                    state_d = ST_EXT_DRIVE;
                    cnt_d   = len_m1;
                end
            end
            ST_POR_DRIVE, ST_EXT_DRIVE: begin
                if (req_i) begin
                    state_d = ST_EXT_DRIVE;
                    cnt_d   = len_m1;
                end else if (cnt_q == '0) begin
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_POR_DRIVE;
            cnt_q   <= CNT_W'(1);
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        drive_o = (state_q != ST_IDLE);
    end

    p_start_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && req_i) |=> (drive_o && cnt_q == $past(len_m1)));

    p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !req_i && cnt_q == '0) |=> !drive_o);

    p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && req_i) |=> (state_q == ST_EXT_DRIVE && cnt_q == $past(len_m1)));

endmodule

// File: rtl/rst_pin_regs.sv
module rst_pin_regs
    import rst_pin_pkg::*;
#(
    parameter int EXP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_i,
    input  logic             wr_i,
    input  logic             rd_i,
    input  logic [EXP_W+1:0] wdata_i,
    output logic [EXP_W+1:0] rdata_o,
    input  logic             event_i,
    input  logic             level_i,
    output logic [EXP_W-1:0] exp_o,
    output logic             irq_sel_o,
    output logic             usr_en_o
);
    localparam int REG_W = EXP_W + 2;

    logic sticky_q;
    logic sts_rd;

    always_comb begin
        sts_rd = rd_i && sel_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_o     <= '0;
            irq_sel_o <= 1'b0;
            usr_en_o  <= 1'b1;
        end else if (wr_i && !sel_i) begin
            exp_o     <= wdata_i[EXP_W-1:0];
            irq_sel_o <= wdata_i[EXP_W];
            usr_en_o  <= wdata_i[EXP_W+1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sticky_q <= 1'b0;
        end else if (event_i) begin
            sticky_q <= 1'b1;
        end else if (sts_rd) begin
            sticky_q <= 1'b0;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (sel_i) begin
            rdata_o[STS_STICKY] = sticky_q;
            rdata_o[STS_LEVEL]  = level_i;
        end else begin
            rdata_o = {usr_en_o, irq_sel_o, exp_o};
        end
    end

    p_sticky_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_rd && !event_i) |=> !sticky_q);

    p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_q && !sts_rd) |=> sticky_q);

    initial begin
        assert (REG_W >= 2);
    end

endmodule

// File: rtl/rst_pin_mgr.sv
module rst_pin_mgr
    import rst_pin_pkg::*;
#(
    parameter int EXP_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_slow,
    input  logic             rst_n,
    input  logic             ext_rst_req,
    input  logic             pin_in,
    output logic             pin_out,
    output logic             pin_oe,
    output logic             usr_rst,
    output logic             irq,
    input  logic             reg_sel,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [EXP_W+1:0] reg_wdata,
    output logic [EXP_W+1:0] reg_rdata
);
    logic             drive;
    logic             level;
    logic             pin_event;
    logic [EXP_W-1:0] exp_val;
    logic             irq_sel;
    logic             usr_en;

    rst_pin_pulse #(.EXP_W(EXP_W)) u_pulse (
        .clk     (clk_slow),
        .rst_n   (rst_n),
        .req_i   (ext_rst_req),
        .exp_i   (exp_val),
        .drive_o (drive)
    );

    rst_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk_slow),
        .rst_n   (rst_n),
        .pin_i   (pin_in),
        .drive_i (drive),
        .level_o (level),
        .event_o (pin_event)
    );

    rst_pin_regs #(.EXP_W(EXP_W)) u_regs (
        .clk       (clk_slow),
        .rst_n     (rst_n),
        .sel_i     (reg_sel),
        .wr_i      (reg_wr),
        .rd_i      (reg_rd),
        .wdata_i   (reg_wdata),
        .rdata_o   (reg_rdata),
        .event_i   (pin_event),
        .level_i   (level),
        .exp_o     (exp_val),
        .irq_sel_o (irq_sel),
        .usr_en_o  (usr_en)
    );

    always_ff @(posedge clk_slow or negedge rst_n) begin
        if (!rst_n) begin
            usr_rst <= 1'b0;
            irq     <= 1'b0;
        end else begin
            usr_rst <= pin_event && usr_en && !irq_sel;
            irq     <= pin_event && irq_sel;
        end
    end

    always_comb begin
        pin_out = 1'b0;
        pin_oe  = drive;
    end

    p_quiet_drive_r9: assert property (@(posedge clk_slow) disable iff (!rst_n)
        pin_oe |=> !(usr_rst || irq));

    p_usr_off_r5: assert property (@(posedge clk_slow) disable iff (!rst_n)
        !usr_en |=> !usr_rst);

    p_irq_only_r6: assert property (@(posedge clk_slow) disable iff (!rst_n)
        irq_sel |=> !usr_rst);

    p_single_usr_r4: assert property (@(posedge clk_slow) disable iff (!rst_n)
        usr_rst |=> !usr_rst);

    p_single_irq_r6: assert property (@(posedge clk_slow) disable iff (!rst_n)
        irq |=> !irq);

endmodule

// File: tb/rst_pin_mgr_bench.sv
module rst_pin_mgr_bench;
    localparam int CLK_PERIOD = 10;
    localparam int EXP_W      = 3;
    localparam int REG_W      = EXP_W + 2;

    logic             clk_slow = 1'b0;
    logic             rst_n = 1'b0;
    logic             ext_rst_req = 1'b0;
    logic             ext_lvl = 1'b1;
    logic             pin_in;
    logic             pin_out;
    logic             pin_oe;
    logic             usr_rst;
    logic             irq;
    logic             reg_sel = 1'b0;
    logic             reg_wr = 1'b0;
    logic             reg_rd = 1'b0;
    logic [REG_W-1:0] reg_wdata = '0;
    logic [REG_W-1:0] reg_rdata;

    int checks = 0;
    int errors = 0;
    int usr_cnt = 0;
    int irq_cnt = 0;

    always #(CLK_PERIOD/2) clk_slow = ~clk_slow;

    assign pin_in = pin_oe ? pin_out : ext_lvl;

    rst_pin_mgr #(.EXP_W(EXP_W), .SYNC_STAGES(2)) u_rst_pin_mgr (
        .clk_slow    (clk_slow),
        .rst_n       (rst_n),
        .ext_rst_req (ext_rst_req),
        .pin_in      (pin_in),
        .pin_out     (pin_out),
        .pin_oe      (pin_oe),
        .usr_rst     (usr_rst),
        .irq         (irq),
        .reg_sel     (reg_sel),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata)
    );

    always @(negedge clk_slow) begin
        if (usr_rst) usr_cnt++;
        if (irq) irq_cnt++;
    end

    task automatic chk(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk_slow);
    endtask

    task automatic write_mode(input int e, input bit irq_s, input bit en);
        @(negedge clk_slow);
        reg_sel   = 1'b0;
        reg_wdata = {en, irq_s, 3'(e)};
        reg_wr    = 1'b1;
        @(posedge clk_slow);
        @(negedge clk_slow);
        reg_wr    = 1'b0;
    endtask

    task automatic peek(input bit sel, output int val);
        reg_sel = sel;
        #1;
        val = int'(reg_rdata);
    endtask

    task automatic read_status(output int val);
        @(negedge clk_slow);
        reg_sel = 1'b1;
        #1;
        val = int'(reg_rdata);
        reg_rd = 1'b1;
        @(posedge clk_slow);
        @(negedge clk_slow);
        reg_rd = 1'b0;
    endtask

    // Pulse request for one edge, then count cycles with pin_oe high.
    task automatic measure_pulse(output int len);
        @(negedge clk_slow);
        ext_rst_req = 1'b1;
        @(posedge clk_slow);
        @(negedge clk_slow);
        ext_rst_req = 1'b0;
        len = 0;
        while (pin_oe && len < 1000) begin
            len++;
            @(negedge clk_slow);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk_slow);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v;
        int len;
        int u0;
        int i0;

        // R1: power-on reset
        repeat (3) @(posedge clk_slow);
        @(negedge clk_slow);
        rst_n = 1'b1;
        len = 0;
        while (pin_oe && len < 100) begin
            len++;
            @(negedge clk_slow);
        end
        chk("R1 power-up drive length", len, 2);
        chk("R1 pin_out low", int'(pin_out), 0);
        peek(1'b0, v);
        chk("R1 mode reset value", v, 16);
        wait_cycles(4);
        peek(1'b1, v);
        chk("R7 status idle high level", v, 2);

        // R2 / R9 / R11: sweep every exponent
        for (int e = 0; e < 8; e++) begin
            write_mode(e, 1'b0, 1'b1);
            peek(1'b0, v);
            chk("R11 mode readback", v, 16 + e);
            u0 = usr_cnt;
            measure_pulse(len);
            chk("R2 pulse length", len, 1 << (e + 1));
            wait_cycles(4);
            chk("R9 no user reset from own drive", usr_cnt, u0);
            peek(1'b1, v);
            chk("R9 sticky untouched by own drive", v & 1, 0);
        end

        // R3: restart during a pulse (E=2, length 8)
        write_mode(2, 1'b0, 1'b1);
        @(negedge clk_slow);
        ext_rst_req = 1'b1;
        @(posedge clk_slow);
        @(negedge clk_slow);
        ext_rst_req = 1'b0;
        len = 1;
        @(negedge clk_slow);
        len++;
        @(negedge clk_slow);
        len++;
        ext_rst_req = 1'b1;
        @(posedge clk_slow);
        @(negedge clk_slow);
        ext_rst_req = 1'b0;
        while (pin_oe && len < 1000) begin
            len++;
            @(negedge clk_slow);
        end
        chk("R3 restarted pulse total", len, 11);
        wait_cycles(4);

        // R4 / R7 / R8: user reset
        u0 = usr_cnt;
        i0 = irq_cnt;
        @(negedge clk_slow);
        ext_lvl = 1'b0;
        @(posedge clk_slow);
        @(posedge clk_slow);
        @(negedge clk_slow);
        chk("R4 no pulse before third edge", int'(usr_rst), 0);
        @(posedge clk_slow);
        @(negedge clk_slow);
        chk("R4 pulse after third edge", int'(usr_rst), 1);
        @(negedge clk_slow);
        chk("R4 pulse lasts one cycle", int'(usr_rst), 0);
        wait_cycles(10);
        chk("R4 one pulse while held low", usr_cnt - u0, 1);
        chk("R4 no irq", irq_cnt - i0, 0);
        peek(1'b1, v);
        chk("R7 status level low", (v >> 1) & 1, 0);
        chk("R8 sticky still set", v & 1, 1);
        read_status(v);
        chk("R8 sticky seen by read", v & 1, 1);
        peek(1'b1, v);
        chk("R8 sticky cleared by read", v & 1, 0);
        ext_lvl = 1'b1;
        wait_cycles(4);
        peek(1'b1, v);
        chk("R7 status level high again", (v >> 1) & 1, 1);

        // R5: user reset disabled
        write_mode(0, 1'b0, 1'b0);
        u0 = usr_cnt;
        i0 = irq_cnt;
        ext_lvl = 1'b0;
        wait_cycles(8);
        chk("R5 no user reset when disabled", usr_cnt - u0, 0);
        chk("R5 no irq when disabled", irq_cnt - i0, 0);
        read_status(v);
        chk("R8 sticky set with enable off", v & 1, 1);
        ext_lvl = 1'b1;
        wait_cycles(4);

        // R6: interrupt mode, both enable values
        for (int en = 0; en < 2; en++) begin
            write_mode(0, 1'b1, en[0]);
            u0 = usr_cnt;
            i0 = irq_cnt;
            ext_lvl = 1'b0;
            wait_cycles(8);
            chk("R6 one irq pulse", irq_cnt - i0, 1);
            chk("R6 no user reset in irq mode", usr_cnt - u0, 0);
            read_status(v);
            chk("R8 sticky in irq mode", v & 1, 1);
            ext_lvl = 1'b1;
            wait_cycles(4);
        end

        // R10: pin held low externally across end of own drive
        write_mode(3, 1'b0, 1'b1);
        u0 = usr_cnt;
        @(negedge clk_slow);
        ext_rst_req = 1'b1;
        @(posedge clk_slow);
        @(negedge clk_slow);
        ext_rst_req = 1'b0;
        wait_cycles(3);
        ext_lvl = 1'b0;
        wait_cycles(8);
        chk("R9 no report while still driving", usr_cnt - u0, 0);
        wait_cycles(12);
        chk("R10 one report after release", usr_cnt - u0, 1);
        ext_lvl = 1'b1;
        wait_cycles(4);
        read_status(v);

        // R10: power-up with pin held low
        @(negedge clk_slow);
        rst_n = 1'b0;
        ext_lvl = 1'b0;
        repeat (2) @(posedge clk_slow);
        @(negedge clk_slow);
        u0 = usr_cnt;
        rst_n = 1'b1;
        wait_cycles(10);
        chk("R10 report after power-up hold", usr_cnt - u0, 1);
        peek(1'b1, v);
        chk("R10 sticky after power-up hold", v & 1, 1);
        ext_lvl = 1'b1;
        wait_cycles(4);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule